// File: doc/BRIEF.md
# Inter-Core Interrupt Hub

This block lets each core of a small cluster interrupt any other core. Every core has its own command port: a valid/ready handshake, a two-bit operation code and one core-index argument. A core uses the port to raise an interrupt on a target, to ask whether a target already has one pending, to ask which senders are waiting on itself, and to acknowledge one sender at a time. Each core has one level interrupt output.

Inside, a square matrix holds one pending bit for every ordered pair of target and sender. A target's interrupt line is the OR of its row. Several senders can therefore stack up behind a single asserted line, and the target still recovers every one of them through the source bitmap. It then retires the senders one by one with acknowledges.

Only one command is executed per cycle. When several ports are valid together, the lowest-numbered core is served first. The other ports see ready low and hold their commands until they are served. A read command returns its bitmap on the issuing core's response port in the cycle after acceptance.

Top module: `xcore_irq_hub`

## Requirements
- R1: After reset every pending bit is zero: all interrupt outputs are low, no response is valid, and no port is ready unless it is valid.
- R2: A raise command (op code 0, argument = target) accepted from core s sets pending bit (target, s). The target's interrupt output is high from the clock edge that accepts the command.
- R3: A raise command whose target equals the issuing core, or names no existing core, changes no pending bit.
- R4: A status command (op code 1, argument = target) returns on the issuer's response port, one cycle after acceptance, the target's pending-sender bitmap, with bit s set for sender s. The value is nonzero exactly when the target has an interrupt pending.
- R5: A source command (op code 2, argument unused) returns the issuer's own pending-sender bitmap, bit s for sender s (1, 2, 4, 8 for cores 0 to 3).
- R6: Raises from several senders to one target merge: the target's output stays high and the bitmap shows every sender, until all of them are acknowledged.
- R7: An acknowledge command (op code 3, argument = sender) clears only bit (issuer, sender). Every other pending bit is left unchanged.
- R8: With several ports valid in one cycle, only the lowest-indexed valid port sees ready. A port that is not served keeps its command and is served in a later cycle.
- R9: The response port pulses valid only after an accepted status or source command, never after a raise or an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | NUM_CORES | Per-core command request |
| cmd_op | input | 2*NUM_CORES | Per-core op code (0 raise, 1 status, 2 source, 3 acknowledge) |
| cmd_arg | input | IDXW*NUM_CORES | Per-core core-index argument |
| cmd_ready | output | NUM_CORES | Per-core command accepted this cycle |
| rsp_valid | output | NUM_CORES | Per-core readback valid, one-cycle pulse |
| rsp_data | output | NUM_CORES*NUM_CORES | Per-core readback bitmap |
| irq_out | output | NUM_CORES | Per-core level interrupt |

## Verification
The bench stacks two senders and then three senders on one target, and acknowledges them one at a time. A design that ORed the senders wrongly, or cleared the whole row on an acknowledge, would drop the line early or report a wrong bitmap. A self-targeted raise is checked through the status readback and the line of that core; a design without the guard would interrupt its own issuer. Three ports are made valid in the same cycle to show the ready moving from core to core in index order. A wrong priority, or a lost held command, would show up as a wrong ready pattern or a missing sender bit. Responses after raises are also checked, to catch a design that pulses readback on every command.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    OP_RAISE  = 2'd0,
    OP_STATUS = 2'd1,
    OP_SOURCE = 2'd2,
    OP_ACK    = 2'd3
  } xirq_op_e;
endpackage

// File: rtl/xirq_arbiter.sv
module xirq_arbiter #(
  parameter int NUM_CORES = 4,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] req,
  output logic [NUM_CORES-1:0] gnt,
  output logic [IDXW-1:0]      gnt_idx,
  output logic                 gnt_any
);
  // fixed priority: lowest index wins (last assignment in a descending walk)
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IDXW'(i);
        gnt_any = 1'b1;
      end
    end
  end

  p_onehot_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_gnt_in_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_core0_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);
endmodule

// File: rtl/xirq_pending.sv
module xirq_pending #(
  parameter int NUM_CORES = 4,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [IDXW-1:0]                set_tgt,
  input  logic [IDXW-1:0]                set_src,
  input  logic                           clr_en,
  input  logic [IDXW-1:0]                clr_tgt,
  input  logic [IDXW-1:0]                clr_src,
  output logic [NUM_CORES*NUM_CORES-1:0] rows,
  output logic [NUM_CORES-1:0]           line
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend_q, pend_d;
  logic                                upd;

  // next state: clear first, then set, so a raise always wins a collision
  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_tgt][clr_src] = 1'b0;
    if (set_en) pend_d[set_tgt][set_src] = 1'b1;
  end

  assign upd = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_row
    assign rows[t*NUM_CORES +: NUM_CORES] = pend_q[t];
    assign line[t] = |pend_q[t];

    p_no_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[t][t]);

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_col
      p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_tgt == IDXW'(t) && set_src == IDXW'(s)) |=> pend_q[t][s]);
      p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_tgt == IDXW'(t) && clr_src == IDXW'(s) &&
         !(set_en && set_tgt == IDXW'(t) && set_src == IDXW'(s)))
        |=> !pend_q[t][s]);
      p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(set_en && set_tgt == IDXW'(t) && set_src == IDXW'(s)) &&
         !(clr_en && clr_tgt == IDXW'(t) && clr_src == IDXW'(s)))
        |=> $stable(pend_q[t][s]));
    end
  end
endmodule

// File: rtl/xirq_readback.sv
module xirq_readback #(
  parameter int NUM_CORES = 4,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic [IDXW-1:0]                rd_core,
  input  logic [NUM_CORES-1:0]           rd_bits,
  output logic [NUM_CORES-1:0]           rsp_valid,
  output logic [NUM_CORES*NUM_CORES-1:0] rsp_data
);
  logic [NUM_CORES-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = '0;
    if (rd_en) vld_d[rd_core] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
    logic [NUM_CORES-1:0] data_q;
    logic                 load;
    assign load = rd_en && (rd_core == IDXW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    data_q <= '0;
      else if (load) data_q <= rd_bits;
    end
    assign rsp_data[c*NUM_CORES +: NUM_CORES] = data_q;

    p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[c] |-> $past(rd_en && rd_core == IDXW'(c)));
  end

  assign rsp_valid = vld_q;
endmodule

// File: rtl/xcore_irq_hub.sv
module xcore_irq_hub #(
  parameter int NUM_CORES = 4,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           cmd_valid,
  input  logic [2*NUM_CORES-1:0]         cmd_op,
  input  logic [IDXW*NUM_CORES-1:0]      cmd_arg,
  output logic [NUM_CORES-1:0]           cmd_ready,
  output logic [NUM_CORES-1:0]           rsp_valid,
  output logic [NUM_CORES*NUM_CORES-1:0] rsp_data,
  output logic [NUM_CORES-1:0]           irq_out
);
  import xirq_pkg::*;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CORES-1:0]           gnt;
  logic [IDXW-1:0]                gidx;
  logic                           gany;
  xirq_op_e                       gop;
  logic [IDXW-1:0]                garg;
  logic                           arg_ok;
  logic                           set_en, clr_en, rd_en;
  logic [NUM_CORES-1:0]           rd_bits;
  logic [NUM_CORES*NUM_CORES-1:0] rows;

  // hold every request off while the internal reset is still asserted
  logic [NUM_CORES-1:0] req;
  assign req = rst_int_n ? cmd_valid : '0;

  xirq_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
    .clk(clk), .rst_n(rst_int_n), .req(req),
    .gnt(gnt), .gnt_idx(gidx), .gnt_any(gany)
  );

  assign cmd_ready = gnt;
  assign gop    = xirq_op_e'(cmd_op[gidx*2 +: 2]);
  assign garg   = cmd_arg[gidx*IDXW +: IDXW];
  assign arg_ok = int'(garg) < NUM_CORES;

  // command decode for the single served port
  always_comb begin
    set_en  = 1'b0;
    clr_en  = 1'b0;
    rd_en   = 1'b0;
    rd_bits = '0;
    if (gany) begin
      case (gop)
        OP_RAISE:  set_en = arg_ok && (garg != gidx);
        OP_ACK:    clr_en = arg_ok;
        OP_STATUS: begin
          rd_en = 1'b1;
          if (arg_ok) rd_bits = rows[garg*NUM_CORES +: NUM_CORES];
        end
        default: begin
          rd_en   = 1'b1;
          rd_bits = rows[gidx*NUM_CORES +: NUM_CORES];
        end
      endcase
    end
  end

  xirq_pending #(.NUM_CORES(NUM_CORES)) u_pend (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(set_en), .set_tgt(garg), .set_src(gidx),
    .clr_en(clr_en), .clr_tgt(gidx), .clr_src(garg),
    .rows(rows), .line(irq_out)
  );

  xirq_readback #(.NUM_CORES(NUM_CORES)) u_rb (
    .clk(clk), .rst_n(rst_int_n),
    .rd_en(rd_en), .rd_core(gidx), .rd_bits(rd_bits),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_ready & ~cmd_valid) == '0);
  p_no_rsp_on_write_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gany && (gop == OP_RAISE || gop == OP_ACK)) |=> (rsp_valid == '0));
endmodule

// File: tb/xcore_irq_hub_test.sv
`timescale 1ns/100ps
module xcore_irq_hub_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] cmd_valid = '0;
  logic [2*N-1:0] cmd_op = '0;
  logic [2*N-1:0] cmd_arg = '0;
  logic [N-1:0] cmd_ready, rsp_valid, irq_out;
  logic [N*N-1:0] rsp_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  xcore_irq_hub #(.NUM_CORES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_out(irq_out)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command, wait for ready, return the response sampled a cycle later
  task automatic issue(input int c, input int op, input int arg,
                       output logic rv, output logic [N-1:0] rd);
    @(negedge clk);
    cmd_valid[c] = 1'b1;
    cmd_op[c*2 +: 2]  = 2'(op);
    cmd_arg[c*2 +: 2] = 2'(arg);
    #1;
    while (!cmd_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid[c] = 1'b0;
    rv = rsp_valid[c];
    rd = rsp_data[c*N +: N];
  endtask

  task automatic t_reset;
    chk(irq_out == '0, "R1 irq", int'(irq_out), 0);
    chk(rsp_valid == '0, "R1 rsp", int'(rsp_valid), 0);
    chk(cmd_ready == '0, "R1 ready", int'(cmd_ready), 0);
  endtask

  task automatic t_single;
    logic rv; logic [N-1:0] rd;
    issue(1, 0, 2, rv, rd);
    chk(irq_out == 4'b0100, "R2 irq after raise", int'(irq_out), 4);
    chk(!rv, "R9 no rsp after raise", int'(rv), 0);
    issue(0, 1, 2, rv, rd);
    chk(rv && rd == 4'b0010, "R4 status of target", int'(rd), 2);
    issue(0, 1, 3, rv, rd);
    chk(rv && rd == 4'b0000, "R4 status idle target", int'(rd), 0);
    issue(2, 2, 0, rv, rd);
    chk(rv && rd == 4'b0010, "R5 source bitmap", int'(rd), 2);
  endtask

  task automatic t_merge;
    logic rv; logic [N-1:0] rd;
    issue(3, 0, 2, rv, rd);
    issue(2, 2, 0, rv, rd);
    chk(rd == 4'b1010, "R6 merged bitmap", int'(rd), 10);
    issue(2, 3, 1, rv, rd);
    chk(!rv, "R9 no rsp after ack", int'(rv), 0);
    chk(irq_out[2] == 1'b1, "R6 line held", int'(irq_out), 4);
    issue(2, 2, 0, rv, rd);
    chk(rd == 4'b1000, "R7 only one sender cleared", int'(rd), 8);
    issue(2, 3, 3, rv, rd);
    chk(irq_out == '0, "R6 line drops after last ack", int'(irq_out), 0);
  endtask

  task automatic t_self;
    logic rv; logic [N-1:0] rd;
    issue(1, 0, 1, rv, rd);
    chk(irq_out == '0, "R3 self raise line", int'(irq_out), 0);
    issue(0, 1, 1, rv, rd);
    chk(rd == '0, "R3 self raise status", int'(rd), 0);
  endtask

  task automatic t_priority;
    logic rv; logic [N-1:0] rd;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      cmd_valid[c] = 1'b1;
      cmd_op[c*2 +: 2]  = 2'd0;
      cmd_arg[c*2 +: 2] = 2'd3;
    end
    #1 chk(cmd_ready == 4'b0001, "R8 core0 first", int'(cmd_ready), 1);
    @(negedge clk); cmd_valid[0] = 1'b0;
    #1 chk(cmd_ready == 4'b0010, "R8 core1 held then served", int'(cmd_ready), 2);
    @(negedge clk); cmd_valid[1] = 1'b0;
    #1 chk(cmd_ready == 4'b0100, "R8 core2 last", int'(cmd_ready), 4);
    @(negedge clk); cmd_valid[2] = 1'b0;
    issue(3, 2, 0, rv, rd);
    chk(rd == 4'b0111, "R8 all held commands applied", int'(rd), 7);
    for (int s = 0; s < 3; s++) issue(3, 3, s, rv, rd);
    chk(irq_out == '0, "R7 all acked", int'(irq_out), 0);
  endtask

  initial begin : watchdog
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_merge();
    t_self();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule